// File: doc/BRIEF.md
# Packetized Flash Program and Readback Controller

This block moves a flash image between a host byte stream and a single-line serial flash, one fixed-size packet at a time. In program mode it pulses a request to the host, collects one packet into a local buffer and issues a write enable. It then issues a page program at the current address with the buffered bytes, and polls the flash status until the write has finished. Only after that does it ask the host for the next packet. In readback mode it reads one block from flash into the same buffer and streams the whole block to the host before it fetches the next block.

The flash side is a byte-level request/acknowledge port to a serial transaction engine. Each request carries one byte to shift out and a flag that releases the chip select after that byte. The acknowledge returns the byte shifted in. The address starts at zero and advances by one packet per packet. The job length is given as a count of packets.

Top module: `flash_pkt_ctrl`

## Requirements
- R1: After reset, busy, done, in_ready, out_valid, pkt_req and eng_req are all 0.
- R2: In program mode, in_ready is high only while a packet is being collected. Exactly PKT_BYTES bytes are taken per packet, and no host byte is taken while a flash transaction is pending.
- R3: pkt_req is a one-cycle pulse, raised once each time the block becomes ready for a packet, the first packet included. A job of N packets gives exactly N pulses, and each pulse comes only after the previous packet's write has completed.
- R4: Every page program transaction is preceded by a one-byte transaction of opcode 0x06, with eng_last set on that byte.
- R5: A page program transaction sends 0x02, then address bits 23:16, 15:8 and 7:0, then the PKT_BYTES buffered bytes in arrival order. eng_last is set only on the final data byte. The first packet goes to address 0, and each later packet to the previous address plus PKT_BYTES.
- R6: After a page program, the block repeats a two-byte status transaction (0x05, then a dummy byte with eng_last set) for as long as bit 0 of the returned byte is 1. It issues no other command until that bit reads 0.
- R7: In readback mode each block is read by 0x03, three address bytes (same order and stepping as R5) and PKT_BYTES dummy bytes, with eng_last set on the last one. The returned bytes are then presented in order on out_valid/out_data, held stable until out_ready. The next read starts only after the whole block has been accepted.
- R8: busy is high from an accepted go until the final packet completes. At that point done rises and stays high until the next accepted go.
- R9: A go with npkts equal to 0 raises done on the next cycle with no flash transaction.
- R10: go is ignored while busy is high.
- R11: While eng_req is high and eng_ack is low, eng_req, eng_wbyte and eng_last hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start pulse, taken only while idle |
| dir_read | input | 1 | 0 = program, 1 = readback |
| npkts | input | NPKT_W | Job length in packets |
| in_valid | input | 1 | Host byte available |
| in_data | input | 8 | Host byte |
| in_ready | output | 1 | Block takes a host byte |
| out_valid | output | 1 | Readback byte available |
| out_data | output | 8 | Readback byte |
| out_ready | input | 1 | Host takes the readback byte |
| pkt_req | output | 1 | One-cycle request for the next packet |
| busy | output | 1 | Job in progress |
| done | output | 1 | Job finished |
| eng_req | output | 1 | Byte transfer request to serial engine |
| eng_wbyte | output | 8 | Byte to shift out |
| eng_last | output | 1 | Release chip select after this byte |
| eng_ack | input | 1 | Engine finished the byte (one cycle) |
| eng_rbyte | input | 8 | Byte shifted in, valid with eng_ack |

## Verification
The assertions assume the engine raises eng_ack only while eng_req is high, for one cycle per byte, and that the host never drops a byte it has been offered. The bench engine model acknowledges only pending requests, clears each acknowledge on the next cycle, and varies its delay. The host model offers bytes only against received pkt_req credits, with optional gaps, and throttles out_ready with a fixed pattern. Both models are driven on the falling edge, so every handshake is judged on values that stay stable through the rising edge.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_FILL, ST_WREN, ST_PPHDR, ST_PPDAT,
    ST_POLLC, ST_POLLR, ST_RDHDR, ST_RDDAT, ST_DRAIN
  } fpc_state_e;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_STAT = 8'h05;
  localparam logic [7:0] OP_READ = 8'h03;

  // Header byte i of an addressed command: opcode, then address high to low.
  function automatic logic [7:0] hdr_byte(input logic [7:0] op,
                                          input logic [23:0] a,
                                          input logic [1:0] i);
    case (i)
      2'd0:    return op;
      2'd1:    return a[23:16];
      2'd2:    return a[15:8];
      default: return a[7:0];
    endcase
  endfunction

  function automatic logic [23:0] next_addr(input logic [23:0] a,
                                            input int unsigned step);
    return a + 24'(step);
  endfunction
endpackage

// File: rtl/fpc_buf.sv
module fpc_buf #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/fpc_track.sv
module fpc_track #(
  parameter int PKT_BYTES = 256,
  parameter int NPKT_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [NPKT_W-1:0] npkts_i,
  input  logic              step,
  output logic [23:0]       addr_o,
  output logic              last_o
);
  import fpc_pkg::*;

  logic [NPKT_W-1:0] cnt, total;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_o <= '0;
      cnt    <= '0;
      total  <= '0;
    end else if (load) begin
      addr_o <= '0;
      cnt    <= '0;
      total  <= npkts_i;
    end else if (step) begin
      addr_o <= next_addr(addr_o, PKT_BYTES);
      cnt    <= cnt + NPKT_W'(1);
    end
  end

  assign last_o = (cnt + NPKT_W'(1)) == total;
endmodule

// File: rtl/flash_pkt_ctrl.sv
module flash_pkt_ctrl #(
  parameter int PKT_BYTES = 256,
  parameter int NPKT_W = 17,
  localparam int IDX_W = $clog2(PKT_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              dir_read,
  input  logic [NPKT_W-1:0] npkts,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [7:0]        out_data,
  input  logic              out_ready,
  output logic              pkt_req,
  output logic              busy,
  output logic              done,
  output logic              eng_req,
  output logic [7:0]        eng_wbyte,
  output logic              eng_last,
  input  logic              eng_ack,
  input  logic [7:0]        eng_rbyte
);
  import fpc_pkg::*;

  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(PKT_BYTES - 1);
  localparam logic [IDX_W-1:0] HDR_END = IDX_W'(3);

  fpc_state_e state, state_n;
  logic [IDX_W-1:0] idx, idx_n;
  logic [23:0] addr;
  logic last_pkt, step, load, done_set;
  logic [7:0] buf_rd;

  // Named events
  logic fill_hs, out_hs, eng_hs, idx_at_end, wip;
  assign fill_hs    = in_valid && in_ready;
  assign out_hs     = out_valid && out_ready;
  assign eng_hs     = eng_req && eng_ack;
  assign idx_at_end = (idx == IDX_END);
  assign wip        = eng_rbyte[0];

  fpc_buf #(.DEPTH(PKT_BYTES)) u_buf (
    .clk   (clk),
    .we    (fill_hs || (state == ST_RDDAT && eng_hs)),
    .waddr (idx),
    .wdata (fill_hs ? in_data : eng_rbyte),
    .raddr (idx),
    .rdata (buf_rd)
  );

  fpc_track #(.PKT_BYTES(PKT_BYTES), .NPKT_W(NPKT_W)) u_trk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .npkts_i (npkts),
    .step    (step),
    .addr_o  (addr),
    .last_o  (last_pkt)
  );

  assign in_ready  = (state == ST_FILL);
  assign out_valid = (state == ST_DRAIN);
  assign out_data  = buf_rd;
  assign busy      = (state != ST_IDLE);
  assign eng_req   = state inside {ST_WREN, ST_PPHDR, ST_PPDAT, ST_POLLC,
                                   ST_POLLR, ST_RDHDR, ST_RDDAT};

  always_comb begin
    eng_wbyte = 8'h00;
    eng_last  = 1'b0;
    case (state)
      ST_WREN:  begin eng_wbyte = OP_WREN; eng_last = 1'b1; end
      ST_PPHDR: eng_wbyte = hdr_byte(OP_PROG, addr, idx[1:0]);
      ST_PPDAT: begin eng_wbyte = buf_rd; eng_last = idx_at_end; end
      ST_POLLC: eng_wbyte = OP_STAT;
      ST_POLLR: eng_last = 1'b1;
      ST_RDHDR: eng_wbyte = hdr_byte(OP_READ, addr, idx[1:0]);
      ST_RDDAT: eng_last = idx_at_end;
      default:  ;
    endcase
  end

  always_comb begin
    state_n  = state;
    idx_n    = idx;
    step     = 1'b0;
    load     = 1'b0;
    done_set = 1'b0;
    case (state)
      ST_IDLE: if (go) begin
        load  = 1'b1;
        idx_n = '0;
        if (npkts == '0)   done_set = 1'b1;
        else if (dir_read) state_n = ST_RDHDR;
        else               state_n = ST_FILL;
      end
      ST_FILL: if (fill_hs) begin
        idx_n = idx + 1'b1;
        if (idx_at_end) begin state_n = ST_WREN; idx_n = '0; end
      end
      ST_WREN: if (eng_hs) state_n = ST_PPHDR;
      ST_PPHDR: if (eng_hs) begin
        idx_n = idx + 1'b1;
        if (idx == HDR_END) begin state_n = ST_PPDAT; idx_n = '0; end
      end
      ST_PPDAT: if (eng_hs) begin
        idx_n = idx + 1'b1;
        if (idx_at_end) begin state_n = ST_POLLC; idx_n = '0; end
      end
      ST_POLLC: if (eng_hs) state_n = ST_POLLR;
      ST_POLLR: if (eng_hs) begin
        if (wip) state_n = ST_POLLC;
        else begin
          step = 1'b1;
          if (last_pkt) begin state_n = ST_IDLE; done_set = 1'b1; end
          else state_n = ST_FILL;
        end
      end
      ST_RDHDR: if (eng_hs) begin
        idx_n = idx + 1'b1;
        if (idx == HDR_END) begin state_n = ST_RDDAT; idx_n = '0; end
      end
      ST_RDDAT: if (eng_hs) begin
        idx_n = idx + 1'b1;
        if (idx_at_end) begin state_n = ST_DRAIN; idx_n = '0; end
      end
      ST_DRAIN: if (out_hs) begin
        idx_n = idx + 1'b1;
        if (idx_at_end) begin
          step  = 1'b1;
          idx_n = '0;
          if (last_pkt) begin state_n = ST_IDLE; done_set = 1'b1; end
          else state_n = ST_RDHDR;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      idx     <= '0;
      done    <= 1'b0;
      pkt_req <= 1'b0;
    end else begin
      state   <= state_n;
      idx     <= idx_n;
      pkt_req <= (state_n == ST_FILL) && (state != ST_FILL);
      if (done_set)  done <= 1'b1;
      else if (load) done <= 1'b0;
    end
  end
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
  parameter int NPKT_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              go,
  input logic [NPKT_W-1:0] npkts,
  input logic              in_ready,
  input logic              out_valid,
  input logic [7:0]        out_data,
  input logic              out_ready,
  input logic              pkt_req,
  input logic              busy,
  input logic              done,
  input logic              eng_req,
  input logic [7:0]        eng_wbyte,
  input logic              eng_last,
  input logic              eng_ack
);
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && !eng_ack |=> eng_req && $stable(eng_wbyte) && $stable(eng_last));

  assert_pkt_req_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_req |=> !pkt_req);

  assert_pkt_req_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_req |-> in_ready);

  assert_no_take_during_flash_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && eng_req));

  assert_drain_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && eng_req));

  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_empty_job_R9: assert property (@(posedge clk) disable iff (!rst_n)
    go && !busy && npkts == '0 |=> done && !busy);
endmodule

bind flash_pkt_ctrl fpc_checker #(.NPKT_W(NPKT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .go        (go),
  .npkts     (npkts),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_ready (out_ready),
  .pkt_req   (pkt_req),
  .busy      (busy),
  .done      (done),
  .eng_req   (eng_req),
  .eng_wbyte (eng_wbyte),
  .eng_last  (eng_last),
  .eng_ack   (eng_ack)
);

// File: tb/sim_flash_pkt_ctrl.sv
`timescale 1ns/1ps
module sim_flash_pkt_ctrl;
  localparam int PKT = 8;
  localparam int NW = 4;
  localparam int FSZ = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0, dir_read = 1'b0;
  logic [NW-1:0] npkts = '0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, out_valid, out_ready = 1'b0, pkt_req, busy, done;
  logic eng_req, eng_last, eng_ack = 1'b0;
  logic [7:0] out_data, eng_wbyte, eng_rbyte = 8'h00;

  always #2.5 clk = ~clk;

  flash_pkt_ctrl #(.PKT_BYTES(PKT), .NPKT_W(NW)) u0 (.*);

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] img(input int i, input int seed);
    return 8'((i * 37 + seed * 11 + 5) & 255);
  endfunction

  // Bench models
  logic [7:0] fmem [FSZ];
  int seed = 0, eng_dly = 0, poll_cfg = 0, thr = 0, cyc = 0;
  int pos = 0, dly_cnt = 0, wip_left = 0, outstanding = 0, txn = 0;
  int pp_cnt = 0, rd_cnt = 0, pp_exp = 0, rd_exp = 0;
  int sent = 0, credits = 0, preq_cnt = 0, rcv = 0, ord_err = 0, rb_err = 0;
  logic [7:0] op = 8'h00;
  logic [23:0] fa = '0;
  bit wel = 0, snd_hs = 0, prev_preq = 0, active = 0;

  task automatic service();
    logic [7:0] b, r;
    b = eng_wbyte;
    r = 8'h00;
    if (pos == 0) begin
      op = b;
      txn++;
      if (wip_left > 0 && b != 8'h05) begin ord_err++; chk(0, "R6 command while busy", b, 5); end
      if (b == 8'h02 && !wel) chk(0, "R4 program without write enable", 0, 1);
      if (b == 8'h03 && outstanding != 0) chk(0, "R7 read before drain", outstanding, 0);
    end else begin
      case (op)
        8'h02: begin
          if (pos <= 3) fa = {fa[15:0], b};
          if (pos == 3) chk(int'(fa) == pp_exp, "R5 program address", int'(fa), pp_exp);
          if (pos >= 4) fmem[(int'(fa) + pos - 4) % FSZ] = b;
        end
        8'h03: begin
          if (pos <= 3) fa = {fa[15:0], b};
          if (pos == 3) chk(int'(fa) == rd_exp, "R7 read address", int'(fa), rd_exp);
          if (pos >= 4) begin r = fmem[(int'(fa) + pos - 4) % FSZ]; outstanding++; end
        end
        8'h05: begin
          r = {7'd0, wip_left > 0};
          if (wip_left > 0) wip_left--;
        end
        default: ;
      endcase
    end
    eng_rbyte = r;
    if (eng_last) begin
      case (op)
        8'h06: begin if (pos != 0) chk(0, "R4 enable length", pos, 0); wel = 1; end
        8'h02: begin
          if (pos != 3 + PKT) chk(0, "R5 program length", pos, 3 + PKT);
          wel = 0; wip_left = poll_cfg; pp_exp += PKT; pp_cnt++;
        end
        8'h03: begin
          if (pos != 3 + PKT) chk(0, "R7 read length", pos, 3 + PKT);
          rd_exp += PKT; rd_cnt++;
        end
        8'h05: if (pos != 1) chk(0, "R6 status length", pos, 1);
        default: ;
      endcase
      pos = 0;
    end else pos++;
  endtask

  initial forever begin
    @(negedge clk);
    cyc++;
    if (active) begin
      // engine
      if (eng_ack) eng_ack = 1'b0;
      else if (eng_req) begin
        if (dly_cnt < eng_dly) dly_cnt++;
        else begin dly_cnt = 0; service(); eng_ack = 1'b1; end
      end
      // host sender
      if (snd_hs) sent++;
      if (pkt_req) begin
        if (prev_preq) chk(0, "R3 pulse width", 2, 1);
        if (sent != preq_cnt * PKT || wip_left != 0)
          chk(0, "R3 request before write complete", sent, preq_cnt * PKT);
        preq_cnt++;
        credits++;
      end
      prev_preq = pkt_req;
      in_valid = (sent < credits * PKT) && !(thr != 0 && (cyc % 3 == 1));
      in_data = img(sent, seed);
      snd_hs = in_valid && in_ready;
      // host receiver
      out_ready = !(thr != 0 && (cyc % 4 == 2));
      if (out_valid && out_ready) begin
        if (out_data != img(rcv, seed)) begin
          rb_err++;
          chk(0, "R7 readback byte", out_data, img(rcv, seed));
        end
        outstanding--;
        rcv++;
      end
    end
  end

  task automatic prep(input int s, input int d, input int p, input int t);
    seed = s; eng_dly = d; poll_cfg = p; thr = t;
    pos = 0; dly_cnt = 0; wip_left = 0; outstanding = 0; txn = 0;
    pp_cnt = 0; rd_cnt = 0; pp_exp = 0; rd_exp = 0; wel = 0;
    sent = 0; credits = 0; preq_cnt = 0; rcv = 0; ord_err = 0; rb_err = 0;
    snd_hs = 0; prev_preq = 0; active = 1;
  endtask

  task automatic launch(input bit rd, input int n);
    @(negedge clk);
    go = 1'b1; dir_read = rd; npkts = NW'(n);
    @(negedge clk);
    go = 1'b0;
  endtask

  task automatic wait_done();
    for (int t = 0; t < 20000 && !done; t++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!busy && !done && !in_ready && !out_valid && !pkt_req && !eng_req,
        "R1 reset outputs", {busy, done, in_ready, out_valid, pkt_req, eng_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Program sweep
    for (int n = 1; n <= 3; n++)
      for (int p = 0; p <= 2; p++)
        for (int d = 0; d <= 1; d++) begin
          for (int i = 0; i < FSZ; i++) fmem[i] = 8'hFF;
          prep(n * 7 + p + d, d, p, d);
          launch(1'b0, n);
          chk(busy && !done, "R8 busy after go", {busy, done}, 2);
          wait_done();
          chk(done && !busy, "R8 done at end", {done, busy}, 2);
          chk(preq_cnt == n, "R3 request count", preq_cnt, n);
          chk(sent == n * PKT, "R2 bytes taken", sent, n * PKT);
          chk(pp_cnt == n, "R5 program count", pp_cnt, n);
          for (int i = 0; i < FSZ; i++) begin
            logic [7:0] e;
            e = (i < n * PKT) ? img(i, seed) : 8'hFF;
            if (fmem[i] != e) chk(0, "R5 flash content", fmem[i], e);
          end
          chk(ord_err == 0, "R6 status polling order", ord_err, 0);
        end

    // done holds until the next go
    repeat (5) @(negedge clk);
    chk(done == 1'b1, "R8 done held", done, 1);

    // Readback sweep
    for (int n = 1; n <= 3; n++)
      for (int t = 0; t <= 1; t++)
        for (int d = 0; d <= 1; d++) begin
          prep(n * 5 + t * 3 + d, d, 0, t);
          for (int i = 0; i < FSZ; i++) fmem[i] = img(i, seed);
          launch(1'b1, n);
          chk(!done, "R8 done cleared by go", done, 0);
          wait_done();
          chk(done && !busy, "R8 readback done", {done, busy}, 2);
          chk(rcv == n * PKT, "R7 bytes returned", rcv, n * PKT);
          chk(rd_cnt == n, "R7 read count", rd_cnt, n);
          chk(rb_err == 0, "R7 readback data", rb_err, 0);
          chk(preq_cnt == 0 && pp_cnt == 0, "R7 no program in readback", preq_cnt + pp_cnt, 0);
        end

    // Empty job
    prep(1, 0, 0, 0);
    launch(1'b0, 0);
    chk(done && !busy, "R9 empty job done", {done, busy}, 2);
    repeat (3) @(negedge clk);
    chk(txn == 0 && preq_cnt == 0, "R9 no activity", txn + preq_cnt, 0);

    // go while busy is ignored
    for (int i = 0; i < FSZ; i++) fmem[i] = 8'hFF;
    prep(9, 1, 1, 0);
    launch(1'b0, 2);
    repeat (15) @(negedge clk);
    go = 1'b1; dir_read = 1'b1; npkts = NW'(1);
    @(negedge clk);
    go = 1'b0;
    wait_done();
    chk(pp_cnt == 2 && rd_cnt == 0, "R10 busy go ignored", pp_cnt * 10 + rd_cnt, 20);
    chk(fmem[2 * PKT - 1] == img(2 * PKT - 1, 9), "R10 job completed",
        fmem[2 * PKT - 1], img(2 * PKT - 1, 9));
    active = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule